// File: doc/BRIEF.md
# Timer Channel Interrupt Flag Unit

This block holds the interrupt status of an eight-channel capture/compare timer and of its free-running counter's overflow. Event strobes arrive from the capture and compare logic, from the pulse accumulators and from the overflow detector. Each strobe sets a sticky flag bit. The block drives one registered interrupt request per flag, and each request is gated by an enable bit.

Flags are read and cleared through a small register port. In normal mode software clears a bit by writing a one to it. In fast-clear mode write-one-to-clear is switched off. A flag is then cleared as a side effect of the access that services its channel: reading a capture channel's data register, writing a compare channel's data register, or any access to the counter for the overflow flag.

A delay stage can stand in for the raw capture strobe. A paired-capture mode raises a channel flag only on every second capture.

Top module: `tmr_flag_unit`

## Requirements
- R1: After reset all channel flags and the overflow flag are 0, `reg_rdata` is 0 and every interrupt request is 0.
- R2: A strobe on `ic_evt[x]` or `oc_evt[x]` sets channel flag x one clock later. Reading `reg_sel`=0 returns the channel flags, with bit x belonging to channel x.
- R3: With `fast_clr`=0, writing `reg_sel`=0 clears every channel flag whose `reg_wdata` bit is 1 and leaves bits written 0 unchanged. Writing `reg_sel`=1 with bit 7 set clears the overflow flag.
- R4: With `fast_clr`=1, writes to `reg_sel`=0 clear nothing. An access with `reg_sel`=2 to channel `reg_ch` clears that channel's flag when it is a read and `ch_is_oc` is 0, or a write and `ch_is_oc` is 1. Other channel accesses clear nothing, and with `fast_clr`=0 channel accesses clear nothing.
- R5: With `fast_clr`=1, any read or write with `reg_sel`=3 clears the overflow flag. With `fast_clr`=0 such an access leaves it set, and with `fast_clr`=1 writing `reg_sel`=1 does not clear it.
- R6: `pacb_evt` sets channel flag 0. `pa8_evt[i]` sets channel flag i for the channels 0 to 3.
- R7: With `dly_en`=1 the capture strobe no longer sets a flag, and `dly_done[x]` sets flag x instead. With `dly_en`=0, `dly_done` has no effect.
- R8: With `pair_mode`=1 and `ovw_prot`=1, only every second capture on a channel sets its flag. Compare strobes still set it at once, and with either control at 0 every capture sets it.
- R9: A set and a clear of the same flag in the same cycle leave the flag set.
- R10: `irq_ch[x]` is the registered AND of flag x and `ch_ie[x]`, and `irq_ovf` is the registered AND of the overflow flag and `ovf_ie`. Both follow the flag in the cycle it changes.
- R11: `ovf_evt` sets the overflow flag. Reading `reg_sel`=1 returns it in bit 7 with bits 6 to 0 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_clr | input | 1 | 1 selects clearing by access instead of write-one-to-clear |
| dly_en | input | 1 | 1 makes delayed capture strobes the set source |
| pair_mode | input | 1 | Paired-capture mode request |
| ovw_prot | input | 1 | Overwrite protection; with pair_mode enables paired capture |
| ic_evt | input | 8 | Per-channel input-capture strobes |
| oc_evt | input | 8 | Per-channel output-compare strobes |
| dly_done | input | 8 | Per-channel delayed-capture strobes |
| pacb_evt | input | 1 | 16-bit pulse accumulator event, sets channel 0 |
| pa8_evt | input | 4 | 8-bit pulse accumulator events, set channels 0 to 3 |
| ovf_evt | input | 1 | Counter overflow strobe |
| ch_is_oc | input | 8 | 1 marks a channel as compare, 0 as capture |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | 0 channel flags, 1 overflow flag, 2 channel data, 3 counter |
| reg_ch | input | 3 | Channel addressed when reg_sel is 2 |
| reg_wdata | input | 8 | Write data |
| ch_ie | input | 8 | Channel interrupt enables |
| ovf_ie | input | 1 | Overflow interrupt enable |
| reg_rdata | output | 8 | Registered read data |
| irq_ch | output | 8 | Channel interrupt requests |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
A set strobe and a clear of the same flag can land in the same cycle. The bench provokes this twice. First it raises `ic_evt` for a channel whose flag is already set while writing a one to that bit in normal mode. Then, in fast mode, it asserts `ovf_evt` during a counter read. In both cases the flag must read back as set afterwards. A companion case shows that the same clear, applied without the strobe, does remove the flag.

// File: rtl/tfu_pkg.sv
package tfu_pkg;
  typedef enum logic [1:0] {
    SEL_CHF   = 2'd0,
    SEL_OVF   = 2'd1,
    SEL_CHDAT = 2'd2,
    SEL_CNT   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tfu_set_path.sv
module tfu_set_path #(
  parameter int NCH  = 8,
  parameter int NPA8 = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dly_en,
  input  logic            pair_act,
  input  logic [NCH-1:0]  ic_evt,
  input  logic [NCH-1:0]  oc_evt,
  input  logic [NCH-1:0]  dly_done,
  input  logic            pacb_evt,
  input  logic [NPA8-1:0] pa8_evt,
  output logic [NCH-1:0]  set_ch
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic cap_eff, half_q, cap_set, pa_set;

    // delayed strobe replaces the raw capture when the delay stage is on
    assign cap_eff = dly_en ? dly_done[i] : ic_evt[i];
    assign cap_set = cap_eff && (!pair_act || half_q);

    always_ff @(posedge clk) begin
      if (rst || !pair_act) half_q <= 1'b0;
      else if (cap_eff)     half_q <= !half_q;
    end

    if (i == 0) begin : g_pa0
      assign pa_set = pacb_evt || pa8_evt[0];
    end else if (i < NPA8) begin : g_pa
      assign pa_set = pa8_evt[i];
    end else begin : g_nopa
      assign pa_set = 1'b0;
    end

    assign set_ch[i] = cap_set || oc_evt[i] || pa_set;

    p_pair_arm_r8: assert property (@(posedge clk) disable iff (rst)
      (pair_act && cap_eff && !half_q) |=> half_q);
    p_pair_fire_r8: assert property (@(posedge clk) disable iff (rst)
      (pair_act && cap_eff && half_q) |-> set_ch[i]);
  end
endmodule

// File: rtl/tfu_clear_ctrl.sv
module tfu_clear_ctrl
  import tfu_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fast_clr,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  reg_sel_e        reg_sel,
  input  logic [CH_W-1:0] reg_ch,
  input  logic [NCH-1:0]  reg_wdata,
  input  logic [NCH-1:0]  ch_is_oc,
  output logic [NCH-1:0]  clr_ch,
  output logic            clr_ovf
);
  logic acc_hit;

  // access that services the channel: capture read or compare write
  assign acc_hit = (reg_rd && !ch_is_oc[reg_ch]) || (reg_wr && ch_is_oc[reg_ch]);

  always_comb begin
    clr_ch  = '0;
    clr_ovf = 1'b0;
    if (fast_clr) begin
      if (reg_sel == SEL_CHDAT && acc_hit) clr_ch[reg_ch] = 1'b1;
      if (reg_sel == SEL_CNT && (reg_rd || reg_wr)) clr_ovf = 1'b1;
    end else if (reg_wr) begin
      if (reg_sel == SEL_CHF) clr_ch  = reg_wdata;
      if (reg_sel == SEL_OVF) clr_ovf = reg_wdata[NCH-1];
    end
  end

  p_fast_no_w1c_r4: assert property (@(posedge clk) disable iff (rst)
    (fast_clr && reg_wr && reg_sel == SEL_CHF) |-> (clr_ch == '0 && !clr_ovf));
  p_fast_ovf_w1c_r5: assert property (@(posedge clk) disable iff (rst)
    (fast_clr && reg_sel == SEL_OVF) |-> !clr_ovf);
endmodule

// File: rtl/tfu_flag_reg.sv
module tfu_flag_reg
  import tfu_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_ch,
  input  logic           set_ovf,
  input  logic [NCH-1:0] clr_ch,
  input  logic           clr_ovf,
  input  logic [NCH-1:0] ch_ie,
  input  logic           ovf_ie,
  input  logic           reg_rd,
  input  reg_sel_e       reg_sel,
  output logic [NCH-1:0] reg_rdata,
  output logic [NCH-1:0] irq_ch,
  output logic           irq_ovf
);
  logic [NCH-1:0] flags_q, flags_nxt;
  logic           tof_q, tof_nxt;

  // set has priority so that no event is lost
  assign flags_nxt = (flags_q & ~clr_ch) | set_ch;
  assign tof_nxt   = (tof_q & !clr_ovf) | set_ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q   <= '0;
      tof_q     <= 1'b0;
      irq_ch    <= '0;
      irq_ovf   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      flags_q <= flags_nxt;
      tof_q   <= tof_nxt;
      irq_ch  <= flags_nxt & ch_ie;
      irq_ovf <= tof_nxt & ovf_ie;
      if (reg_rd) begin
        case (reg_sel)
          SEL_CHF: reg_rdata <= flags_q;
          SEL_OVF: reg_rdata <= {tof_q, {(NCH-1){1'b0}}};
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (set_ch != '0) |=> ((flags_q & $past(set_ch)) == $past(set_ch)));
  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_ch == '0) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  p_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
    ((irq_ch & ~flags_q) == '0) && (!irq_ovf || tof_q));
  p_ovf_read_r11: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_sel == SEL_OVF) |=> (reg_rdata[NCH-2:0] == '0));
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit
  import tfu_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int NPA8 = 4,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fast_clr,
  input  logic            dly_en,
  input  logic            pair_mode,
  input  logic            ovw_prot,
  input  logic [NCH-1:0]  ic_evt,
  input  logic [NCH-1:0]  oc_evt,
  input  logic [NCH-1:0]  dly_done,
  input  logic            pacb_evt,
  input  logic [NPA8-1:0] pa8_evt,
  input  logic            ovf_evt,
  input  logic [NCH-1:0]  ch_is_oc,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [1:0]      reg_sel,
  input  logic [CH_W-1:0] reg_ch,
  input  logic [NCH-1:0]  reg_wdata,
  input  logic [NCH-1:0]  ch_ie,
  input  logic            ovf_ie,
  output logic [NCH-1:0]  reg_rdata,
  output logic [NCH-1:0]  irq_ch,
  output logic            irq_ovf
);
  logic [NCH-1:0] set_ch, clr_ch;
  logic           clr_ovf;
  reg_sel_e       sel;

  assign sel = reg_sel_e'(reg_sel);

  tfu_set_path #(.NCH(NCH), .NPA8(NPA8)) u_set (
    .clk(clk), .rst(rst), .dly_en(dly_en), .pair_act(pair_mode && ovw_prot),
    .ic_evt(ic_evt), .oc_evt(oc_evt), .dly_done(dly_done),
    .pacb_evt(pacb_evt), .pa8_evt(pa8_evt), .set_ch(set_ch)
  );

  tfu_clear_ctrl #(.NCH(NCH), .CH_W(CH_W)) u_clr (
    .clk(clk), .rst(rst), .fast_clr(fast_clr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(sel), .reg_ch(reg_ch), .reg_wdata(reg_wdata), .ch_is_oc(ch_is_oc),
    .clr_ch(clr_ch), .clr_ovf(clr_ovf)
  );

  tfu_flag_reg #(.NCH(NCH)) u_flags (
    .clk(clk), .rst(rst), .set_ch(set_ch), .set_ovf(ovf_evt),
    .clr_ch(clr_ch), .clr_ovf(clr_ovf), .ch_ie(ch_ie), .ovf_ie(ovf_ie),
    .reg_rd(reg_rd), .reg_sel(sel), .reg_rdata(reg_rdata),
    .irq_ch(irq_ch), .irq_ovf(irq_ovf)
  );
endmodule

// File: tb/test_tmr_flag_unit.sv
module test_tmr_flag_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic fast_clr = 0, dly_en = 0, pair_mode = 0, ovw_prot = 0;
  logic [7:0] ic_evt = 0, oc_evt = 0, dly_done = 0, ch_is_oc = 0, ch_ie = 0, reg_wdata = 0;
  logic pacb_evt = 0, ovf_evt = 0, reg_wr = 0, reg_rd = 0, ovf_ie = 0;
  logic [3:0] pa8_evt = 0;
  logic [1:0] reg_sel = 0;
  logic [2:0] reg_ch = 0;
  logic [7:0] reg_rdata, irq_ch;
  logic irq_ovf;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_flag_unit i_tmr_flag_unit (
    .clk(clk), .rst(rst), .fast_clr(fast_clr), .dly_en(dly_en), .pair_mode(pair_mode),
    .ovw_prot(ovw_prot), .ic_evt(ic_evt), .oc_evt(oc_evt), .dly_done(dly_done),
    .pacb_evt(pacb_evt), .pa8_evt(pa8_evt), .ovf_evt(ovf_evt), .ch_is_oc(ch_is_oc),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_ch(reg_ch),
    .reg_wdata(reg_wdata), .ch_ie(ch_ie), .ovf_ie(ovf_ie), .reg_rdata(reg_rdata),
    .irq_ch(irq_ch), .irq_ovf(irq_ovf)
  );

  // fields: {ic, oc, w1c mask, flags after set, flags after clear}
  localparam logic [39:0] TBL [5] = '{
    {8'h01, 8'h80, 8'h00, 8'h81, 8'h81},
    {8'h0C, 8'h00, 8'h01, 8'h8D, 8'h8C},
    {8'h00, 8'h30, 8'hF0, 8'hBC, 8'h0C},
    {8'h42, 8'h00, 8'h0C, 8'h4E, 8'h42},
    {8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs change at a falling edge; one call spans exactly one rising edge
  task automatic step();
    @(negedge clk);
    ic_evt = 0; oc_evt = 0; dly_done = 0; pacb_evt = 0; pa8_evt = 0; ovf_evt = 0;
    reg_wr = 0; reg_rd = 0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [2:0] ch, output logic [7:0] d);
    reg_rd = 1; reg_sel = s; reg_ch = ch;
    step();
    d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] s, input logic [2:0] ch, input logic [7:0] d);
    reg_wr = 1; reg_sel = s; reg_ch = ch; reg_wdata = d;
    step();
  endtask

  task automatic clear_all();
    fast_clr = 0;
    wr(2'd0, 3'd0, 8'hFF);
    wr(2'd1, 3'd0, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 irq", {irq_ch[6:0], irq_ovf}, 8'h00);
    rd(2'd0, 3'd0, rv); chk("R1 flags", rv, 8'h00);
    rd(2'd1, 3'd0, rv); chk("R1 ovf", rv, 8'h00);

    // R2/R3 table walk
    for (int k = 0; k < 5; k++) begin
      ic_evt = TBL[k][39:32]; oc_evt = TBL[k][31:24];
      step();
      rd(2'd0, 3'd0, rv); chk("R2 set", rv, TBL[k][15:8]);
      wr(2'd0, 3'd0, TBL[k][23:16]);
      rd(2'd0, 3'd0, rv); chk("R3 w1c", rv, TBL[k][7:0]);
    end

    // R3 writing zero has no effect
    ic_evt = 8'h5A; step();
    wr(2'd0, 3'd0, 8'h00);
    rd(2'd0, 3'd0, rv); chk("R3 zero write", rv, 8'h5A);
    clear_all();

    // R4 fast clear by channel access
    ch_is_oc = 8'h20; fast_clr = 1;
    ic_evt = 8'h04; oc_evt = 8'h20; step();
    wr(2'd0, 3'd0, 8'hFF);
    rd(2'd0, 3'd0, rv); chk("R4 w1c blocked", rv, 8'h24);
    wr(2'd2, 3'd2, 8'h00);
    rd(2'd0, 3'd0, rv); chk("R4 capture write no clear", rv, 8'h24);
    rd(2'd2, 3'd2, rv);
    rd(2'd0, 3'd0, rv); chk("R4 capture read clears", rv, 8'h20);
    rd(2'd2, 3'd5, rv);
    rd(2'd0, 3'd0, rv); chk("R4 compare read no clear", rv, 8'h20);
    wr(2'd2, 3'd5, 8'h00);
    rd(2'd0, 3'd0, rv); chk("R4 compare write clears", rv, 8'h00);
    fast_clr = 0;
    ic_evt = 8'h04; step();
    rd(2'd2, 3'd2, rv);
    rd(2'd0, 3'd0, rv); chk("R4 normal mode access", rv, 8'h04);
    clear_all();

    // R5/R11 overflow flag
    ovf_evt = 1; step();
    rd(2'd1, 3'd0, rv); chk("R11 tof bit7", rv, 8'h80);
    rd(2'd3, 3'd0, rv);
    rd(2'd1, 3'd0, rv); chk("R5 normal counter read", rv, 8'h80);
    wr(2'd1, 3'd0, 8'h7F);
    rd(2'd1, 3'd0, rv); chk("R3 ovf write bit7 zero", rv, 8'h80);
    wr(2'd1, 3'd0, 8'h80);
    rd(2'd1, 3'd0, rv); chk("R3 ovf w1c", rv, 8'h00);
    fast_clr = 1;
    ovf_evt = 1; step();
    wr(2'd1, 3'd0, 8'h80);
    rd(2'd1, 3'd0, rv); chk("R5 fast w1c blocked", rv, 8'h80);
    wr(2'd3, 3'd0, 8'h00);
    rd(2'd1, 3'd0, rv); chk("R5 counter write clears", rv, 8'h00);
    // R9 overflow set during counter read
    ovf_evt = 1; reg_rd = 1; reg_sel = 2'd3; step();
    rd(2'd1, 3'd0, rv); chk("R9 ovf set wins", rv, 8'h80);
    rd(2'd3, 3'd0, rv);
    rd(2'd1, 3'd0, rv); chk("R5 counter read clears", rv, 8'h00);
    clear_all();

    // R6 pulse accumulator sources
    pacb_evt = 1; step();
    rd(2'd0, 3'd0, rv); chk("R6 pacb", rv, 8'h01);
    pa8_evt = 4'b1010; step();
    rd(2'd0, 3'd0, rv); chk("R6 pa8", rv, 8'h0B);
    clear_all();

    // R7 delay stage
    dly_en = 1;
    ic_evt = 8'h10; step();
    rd(2'd0, 3'd0, rv); chk("R7 raw capture held", rv, 8'h00);
    dly_done = 8'h10; step();
    rd(2'd0, 3'd0, rv); chk("R7 delayed set", rv, 8'h10);
    dly_en = 0;
    dly_done = 8'h40; step();
    rd(2'd0, 3'd0, rv); chk("R7 done ignored", rv, 8'h10);
    clear_all();

    // R8 paired capture
    pair_mode = 1; ovw_prot = 1;
    ic_evt = 8'h02; step();
    rd(2'd0, 3'd0, rv); chk("R8 first capture", rv, 8'h00);
    ic_evt = 8'h02; step();
    rd(2'd0, 3'd0, rv); chk("R8 second capture", rv, 8'h02);
    oc_evt = 8'h80; step();
    rd(2'd0, 3'd0, rv); chk("R8 compare direct", rv, 8'h82);
    clear_all();
    ovw_prot = 0;
    ic_evt = 8'h02; step();
    rd(2'd0, 3'd0, rv); chk("R8 no protect", rv, 8'h02);
    pair_mode = 0;
    clear_all();

    // R9 set wins over write-one-to-clear
    ic_evt = 8'h08; step();
    ic_evt = 8'h08; reg_wr = 1; reg_sel = 2'd0; reg_wdata = 8'h08; step();
    rd(2'd0, 3'd0, rv); chk("R9 set wins", rv, 8'h08);
    wr(2'd0, 3'd0, 8'h08);
    rd(2'd0, 3'd0, rv); chk("R9 plain clear", rv, 8'h00);

    // R10 interrupt gating
    ch_ie = 8'h0F; ovf_ie = 1;
    ic_evt = 8'h11; step();
    chk("R10 irq_ch", irq_ch, 8'h01);
    ovf_evt = 1; step();
    chk("R10 irq_ovf", {7'd0, irq_ovf}, 8'h01);
    ovf_ie = 0; step();
    chk("R10 irq_ovf masked", {7'd0, irq_ovf}, 8'h00);
    wr(2'd0, 3'd0, 8'h01);
    chk("R10 irq drops", irq_ch, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule